// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Transmitter

This block turns parallel words into a serial bit stream. Each word goes out after an active-high frame sync input. A word arrives over a ready/valid load port and waits in the shift register. Its most-significant bit already sits on the serial output. When the frame sync is seen at a rising bit-clock edge while the block is idle, that cycle is the frame start. A programmable delay of zero, one or two bit periods then runs before the first data bit. After that the word is shifted out MSB first, one bit per bit-clock cycle. An output-enable signal marks the data bits.

With zero delay the frame sync path is combinational. The first bit is already on the output, and output-enable rises in the same cycle that the frame sync goes high. The remaining bits follow on the next rising edges. If a frame begins before a fresh word has been loaded, an underrun flag is raised and the last word is sent again.

The block runs entirely in the bit-clock domain. A separate write strobe updates the delay setting, which is read at each frame start.

Top module: `fsync_tx`

## Requirements
- R1: A frame sends exactly W data bits, most-significant first. Each bit changes only at a rising edge and is held for one full bit period. `txOe` is high exactly while those W bits are on `txData`.
- R2: The frame start is a rising edge at which `fsync` is high while the block is idle. The delay code selects how many bit periods pass between the frame start and the first data bit: 00b gives 0, 01b gives 1 and 10b gives 2.
- R3: Delay code 11b behaves exactly like 10b, giving two bit periods of delay.
- R4: With delay 0, `txOe` goes high in the same cycle that `fsync` is high, with no clock edge needed, and the MSB is already on `txData`. Bits W-2 down to 0 then follow in the cycles after the frame-start edge.
- R5: Reset drives `txData`=0, `txOe`=0, `loadReady`=1 and `underrun`=0, and sets the delay code to 01b. `cfgWe` captures `cfgDelay` at a rising edge.
- R6: While idle and during delay periods, `txOe` is 0 and `txData` shows the MSB of the word waiting in the shifter.
- R7: `loadReady` is 1 only while idle with `fsync` low. A word is taken at a rising edge with `loadValid` and `loadReady` both high. `loadValid` while not ready has no effect on later frames.
- R8: A frame that starts with no word accepted since the previous frame sets `underrun`, visible in the cycle after the frame-start edge, and resends the previous word. The next accepted load clears `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data changes on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Write strobe for the delay code |
| cfgDelay | input | 2 | Delay code to store |
| loadValid | input | 1 | Parallel word offered |
| loadReady | output | 1 | Parallel word can be accepted |
| loadData | input | W | Parallel word |
| fsync | input | 1 | Active-high frame sync |
| txData | output | 1 | Serial data output |
| txOe | output | 1 | High while data bits are driven |
| underrun | output | 1 | Frame started without a fresh word |

## Verification
Each delay code is checked against the exact cycle of every bit. An off-by-one delay counter would shift the whole frame by one cycle. Zero delay is sampled inside the frame-sync cycle itself, before any edge, so a design that registered the sync would show `txOe` low there or would duplicate the MSB. Code 11b is checked against two cycles of delay. Frames without a preceding load must repeat the last word and raise `underrun`. A load offered mid-frame must not leak into the next frame, which a design that accepted loads while busy would do.

// File: rtl/fsync_tx_pkg.sv
package fsync_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_SHIFT} txState_t;

  typedef struct packed {
    logic loadWord;
    logic shiftEn;
    logic reloadPrev;
  } txStrobe_t;

  // code 11b folds onto two periods of delay
  function automatic logic [1:0] decodeDelay(input logic [1:0] code);
    return (code == 2'b11) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/fsync_tx_dp.sv
module fsync_tx_dp
  import fsync_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  txStrobe_t    ctl,
  input  logic [W-1:0] loadData,
  output logic         txData
);
  logic [W-1:0] shReg;
  logic [W-1:0] lastWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      lastWord <= '0;
    end else if (ctl.loadWord) begin
      shReg    <= loadData;
      lastWord <= loadData;
    end else if (ctl.reloadPrev) begin
      shReg    <= lastWord;
    end else if (ctl.shiftEn) begin
      shReg    <= {shReg[W-2:0], 1'b0};
    end
  end

  assign txData = shReg[W-1];

  // R6: without a strobe the waiting word must not move
  a_r6_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadWord && !ctl.shiftEn && !ctl.reloadPrev |=> $stable(shReg));
endmodule

// File: rtl/fsync_tx_ctrl.sv
module fsync_tx_ctrl
  import fsync_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWe,
  input  logic [1:0] cfgDelay,
  input  logic      loadValid,
  input  logic      fsync,
  output logic      loadReady,
  output logic      txOe,
  output logic      underrun,
  output txStrobe_t ctl
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] FULL_M1 = CW'(W - 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  txState_t state;
  logic [CW-1:0] bitsLeft;
  logic [1:0] delayCode;
  logic [1:0] delayEff;
  logic loaded;
  logic frameStart;
  logic lastBit;

  assign delayEff   = decodeDelay(delayCode);
  assign frameStart = (state == ST_IDLE) && fsync;
  assign lastBit    = (state == ST_SHIFT) && (bitsLeft == ONE);
  assign loadReady  = (state == ST_IDLE) && !fsync;

  assign ctl.loadWord   = loadValid && loadReady;
  assign ctl.shiftEn    = (frameStart && delayEff == 2'd0) ||
                          ((state == ST_SHIFT) && !lastBit);
  assign ctl.reloadPrev = lastBit;

  // zero delay: enable follows the sync without waiting for an edge
  assign txOe = (state == ST_SHIFT) || (frameStart && delayEff == 2'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCode <= 2'b01;
    end else if (cfgWe) begin
      delayCode <= cfgDelay;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (fsync) begin
          unique case (delayEff)
            2'd0: begin state <= ST_SHIFT; bitsLeft <= FULL_M1; end
            2'd1: begin state <= ST_SHIFT; bitsLeft <= FULL; end
            default: state <= ST_DELAY;
          endcase
        end
        ST_DELAY: begin
          state    <= ST_SHIFT;
          bitsLeft <= FULL;
        end
        ST_SHIFT: begin
          if (lastBit) state <= ST_IDLE;
          else bitsLeft <= bitsLeft - ONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loaded   <= 1'b0;
      underrun <= 1'b0;
    end else if (ctl.loadWord) begin
      loaded   <= 1'b1;
      underrun <= 1'b0;
    end else if (frameStart) begin
      loaded   <= 1'b0;
      if (!loaded) underrun <= 1'b1;
    end
  end

  // R8: the flag only rises right after a sampled frame sync
  a_r8_underrun_src: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> $past(fsync));
  // R1: the bit counter stays inside one word while shifting
  a_r1_count_range: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SHIFT |-> (bitsLeft >= ONE) && (bitsLeft <= FULL));
  // R1: the edge after the last bit returns to idle
  a_r1_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    lastBit |=> state == ST_IDLE);
  // R6: delay periods never enable the output
  a_r6_delay_quiet: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DELAY |-> !txOe);
  // R7: no word is taken while a frame is in progress
  a_r7_load_idle: assert property (@(posedge clk) disable iff (!rstN)
    txOe |-> !loadReady);
endmodule

// File: rtl/fsync_tx.sv
module fsync_tx
  import fsync_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWe,
  input  logic [1:0]   cfgDelay,
  input  logic         loadValid,
  output logic         loadReady,
  input  logic [W-1:0] loadData,
  input  logic         fsync,
  output logic         txData,
  output logic         txOe,
  output logic         underrun
);
  txStrobe_t ctl;

  fsync_tx_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgDelay(cfgDelay),
    .loadValid(loadValid), .fsync(fsync), .loadReady(loadReady),
    .txOe(txOe), .underrun(underrun), .ctl(ctl)
  );

  fsync_tx_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadData(loadData), .txData(txData)
  );

  initial begin
    a_r1_min_width: assert (W >= 2);
  end
endmodule

// File: tb/fsync_tx_tb_top.sv
`timescale 1ns/1ps
module fsync_tx_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgDelay = 2'b00;
  logic loadValid = 1'b0;
  logic loadReady;
  logic [W-1:0] loadData = '0;
  logic fsync = 1'b0;
  logic txData, txOe, underrun;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  fsync_tx #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgDelay(cfgDelay),
    .loadValid(loadValid), .loadReady(loadReady), .loadData(loadData),
    .fsync(fsync), .txData(txData), .txOe(txOe), .underrun(underrun)
  );

  // {word, delay code, effective delay}
  localparam logic [W+3:0] VEC [6] = '{
    {8'hC3, 2'b00, 2'd0}, {8'h5A, 2'b10, 2'd2}, {8'h81, 2'b01, 2'd1},
    {8'h7E, 2'b11, 2'd2}, {8'h01, 2'b00, 2'd0}, {8'hFF, 2'b10, 2'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runFrame(input logic [W-1:0] w, input logic [1:0] code,
                          input bit doCfg, input bit doLoad, input logic [W-1:0] expWord,
                          input bit expUnder, input int dEff, input bit pokeBusy);
    if (doCfg) begin
      cfgDelay = code; cfgWe = 1'b1;
      @(negedge clk); cfgWe = 1'b0;
    end
    if (doLoad) begin
      chk("R7 ready idle", loadReady, 1);
      loadData = w; loadValid = 1'b1;
      @(negedge clk); loadValid = 1'b0;
      chk("R8 cleared by load", underrun, 0);
    end
    chk("R6 idle msb", txData, expWord[W-1]);
    fsync = 1'b1;
    #1;
    chk("R4 oe in sync cycle", txOe, (dEff == 0));
    chk("R4 msb waiting", txData, expWord[W-1]);
    chk("R7 not ready on sync", loadReady, 0);
    @(negedge clk); fsync = 1'b0;
    chk("R8 underrun", underrun, expUnder);
    for (int k = 0; k <= W - 1 + dEff; k++) begin
      int p;
      p = k + 1 - dEff;
      if (pokeBusy && k == 1) begin
        chk("R7 busy not ready", loadReady, 0);
        loadData = 8'h99; loadValid = 1'b1;
      end else begin
        loadValid = 1'b0;
      end
      if (p < 0) begin
        chk("R2 delay oe", txOe, 0);
        chk("R6 delay data", txData, expWord[W-1]);
      end else if (p < W) begin
        chk("R1 oe", txOe, 1);
        chk("R1 bit", txData, expWord[W-1-p]);
      end else begin
        chk("R1 frame end oe", txOe, 0);
        chk("R6 idle after", txData, expWord[W-1]);
      end
      @(negedge clk);
    end
    loadValid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #12;
    chk("R5 reset data", txData, 0);
    chk("R5 reset oe", txOe, 0);
    chk("R5 reset ready", loadReady, 1);
    chk("R5 reset underrun", underrun, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R5 default delay of one period
    runFrame(8'hA5, 2'b01, 0, 1, 8'hA5, 0, 1, 0);
    // R2 R3 R4 table walk
    foreach (VEC[i]) begin
      runFrame(VEC[i][W+3:4], VEC[i][3:2], 1, 1, VEC[i][W+3:4], 0, int'(VEC[i][1:0]), 0);
    end
    // R8 no load: previous word again
    runFrame(8'h00, 2'b01, 1, 0, 8'hFF, 1, 1, 0);
    // R8 delay-0 underrun then clearing load
    runFrame(8'h00, 2'b00, 1, 0, 8'hFF, 1, 0, 0);
    // R7 load offered mid-frame is dropped
    runFrame(8'h3C, 2'b01, 1, 1, 8'h3C, 0, 1, 1);
    runFrame(8'h00, 2'b01, 0, 0, 8'h3C, 1, 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule